// File: doc/BRIEF.md
# Card Host Controller Status Word

This block holds the 32-bit read-only status word of a memory-card host controller. The command path, the data path, the FIFO and the DMA mover report events to it as single-cycle pulses. Each sticky flag records its event until its own clearing access arrives. Three further bits are live level indications that are sampled at the moment of the read.

Flags leave the word by one of several routes:
- a qualified read of the status word;
- a write to the command register;
- a write to the transmit data register or a read of the receive data register;
- an explicit end-of-response pulse, which applies to the not-busy flag.

A configuration input selects how the underrun and overrun flags clear. Software reads the word through a registered read port.

The event vector is indexed by status bit position, so each producer drives the bit it owns. An event that arrives in the same cycle as a clearing access wins, so no event is lost.

Top module: `card_status_reg`

## Requirements
- R1: A read with `rd_en` high and `rd_addr` equal to the status address (default 8'h10) returns the status word on `rd_data` one cycle later. A read at any other address returns 0 and clears no flag. `rd_data` holds its value while no read is issued.
- R2: After reset `rd_data` is 0, and the sticky flags read 32'h0000_0025: bits 0, 2 and 5 are 1 and all error flags are 0.
- R3: Bits 29, 28, 24, 23, 22, 21, 13, 8 and 3 are set by their event and cleared by a status read. A command write does not clear them.
- R4: Bits 20 to 16 (response errors) are set by their event and cleared only by `cmd_wr`. A status read leaves them set.
- R5: Bits 31 (underrun) and 30 (overrun) clear on a status read when `err_ctl` is 1, and on `cmd_wr` when `err_ctl` is 0. The other trigger has no effect on them.
- R6: Bit 2 (transmit ready) is set by its event and cleared by `tdr_wr`. Bit 1 (receive ready) is set by its event and cleared by `rdr_rd`. A status read clears neither.
- R7: Bit 0 (command ready) is set by its event and cleared by `cmd_wr`.
- R8: Bit 5 (not busy) is set by its event and cleared by `nb_clr`.
- R9: Bits 27, 26 and 12 show `lvl_xfr_done`, `lvl_fifo_empty` and `lvl_read_wait` as sampled in the read cycle. They are not sticky.
- R10: An event in the same cycle as a clearing access leaves the flag set.
- R11: Bits 25, 15, 14, 11, 10, 9, 7, 6 and 4 always read 0, and `evt_set` at those positions or at level positions has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Qualified bus read strobe |
| rd_addr | input | 8 | Bus read address |
| rd_data | output | 32 | Registered read data |
| cmd_wr | input | 1 | Command register write strobe |
| tdr_wr | input | 1 | Transmit data register write strobe |
| rdr_rd | input | 1 | Receive data register read strobe |
| err_ctl | input | 1 | Underrun/overrun clear select (1: status read, 0: command write) |
| evt_set | input | 32 | Set pulses, indexed by status bit position |
| nb_clr | input | 1 | End-of-response pulse that clears not-busy |
| lvl_xfr_done | input | 1 | Live transfer-done level |
| lvl_fifo_empty | input | 1 | Live FIFO-empty level |
| lvl_read_wait | input | 1 | Live read-wait level |

## Verification
The assertions watch on every cycle that:
- an event is never lost to a concurrent clear;
- each representative flag drops on exactly its own trigger, including both settings of the underrun/overrun select;
- a status read leaves response errors and the data-ready flags alone;
- the unused bits stay 0 and a missed address returns 0.

The exact value of the full word as software sees it can only be shown by the bench's read sequences. That covers combinations of flags, a set followed by a clear over several reads, level bits sampled in the read cycle, and the flag values after reset.

// File: rtl/card_status_pkg.sv
package card_status_pkg;

  localparam int REG_W = 32;

  typedef enum logic [3:0] {
    K_NONE,
    K_LEVEL,
    K_RDCLR,
    K_CMDCLR,
    K_SELCLR,
    K_TXRDY,
    K_RXRDY,
    K_NBUSY
  } flag_kind_e;

  // bit positions decoded by software
  localparam int B_UNDERRUN = 31;
  localparam int B_OVERRUN  = 30;
  localparam int B_XFR_DONE = 27;
  localparam int B_FIFO_MT  = 26;
  localparam int B_RD_WAIT  = 12;
  localparam int B_NBUSY    = 5;
  localparam int B_TXRDY    = 2;
  localparam int B_RXRDY    = 1;
  localparam int B_CMDRDY   = 0;

  function automatic flag_kind_e kind_of(input int b);
    case (b)
      B_UNDERRUN, B_OVERRUN:                   return K_SELCLR;
      29, 28, 24, 23, 22, 21, 13, 8, 3:        return K_RDCLR;
      20, 19, 18, 17, 16, B_CMDRDY:            return K_CMDCLR;
      B_XFR_DONE, B_FIFO_MT, B_RD_WAIT:        return K_LEVEL;
      B_TXRDY:                                 return K_TXRDY;
      B_RXRDY:                                 return K_RXRDY;
      B_NBUSY:                                 return K_NBUSY;
      default:                                 return K_NONE;
    endcase
  endfunction

  function automatic bit rst_of(input int b);
    return (b == B_CMDRDY) || (b == B_TXRDY) || (b == B_NBUSY);
  endfunction

endpackage

// File: rtl/status_flag_cell.sv
module status_flag_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  // set has priority over clear so a concurrent event survives
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= RST_VAL;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  a_r10_set_not_lost: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);

endmodule

// File: rtl/status_read_port.sv
module status_read_port #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] status_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_data
);

  assign hit_o = rd_en && (rd_addr == STAT_ADDR);

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= hit_o ? status_i : '0;
  end

  a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit_o) |=> (rd_data == '0));

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/card_status_reg.sv
module card_status_reg
  import card_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              cmd_wr,
  input  logic              tdr_wr,
  input  logic              rdr_rd,
  input  logic              err_ctl,
  input  logic [REG_W-1:0]  evt_set,
  input  logic              nb_clr,
  input  logic              lvl_xfr_done,
  input  logic              lvl_fifo_empty,
  input  logic              lvl_read_wait
);

  logic             rd_hit;
  logic             sel_clr;
  logic [REG_W-1:0] lvl_vec;
  logic [REG_W-1:0] stat_w;

  always_comb begin
    lvl_vec             = '0;
    lvl_vec[B_XFR_DONE] = lvl_xfr_done;
    lvl_vec[B_FIFO_MT]  = lvl_fifo_empty;
    lvl_vec[B_RD_WAIT]  = lvl_read_wait;
  end

  assign sel_clr = err_ctl ? rd_hit : cmd_wr;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    localparam flag_kind_e KIND = kind_of(b);
    if (KIND == K_NONE) begin : g_unused
      assign stat_w[b] = 1'b0;
    end else if (KIND == K_LEVEL) begin : g_level
      assign stat_w[b] = lvl_vec[b];
    end else begin : g_sticky
      logic clr_b;
      assign clr_b = (KIND == K_RDCLR)  ? rd_hit  :
                     (KIND == K_CMDCLR) ? cmd_wr  :
                     (KIND == K_SELCLR) ? sel_clr :
                     (KIND == K_TXRDY)  ? tdr_wr  :
                     (KIND == K_RXRDY)  ? rdr_rd  : nb_clr;
      status_flag_cell #(.RST_VAL(rst_of(b))) i_cell (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_set[b]),
        .clr_i  (clr_b),
        .flag_o (stat_w[b])
      );
    end
  end

  status_read_port #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (REG_W),
    .STAT_ADDR (STAT_ADDR)
  ) i_port (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .status_i (stat_w),
    .hit_o    (rd_hit),
    .rd_data  (rd_data)
  );

  a_r2_reset_ones: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_w[B_CMDRDY] && stat_w[B_TXRDY] && stat_w[B_NBUSY]
                    && !stat_w[31] && !stat_w[20] && !stat_w[3]));

  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !evt_set[29]) |=> !stat_w[29]);

  a_r3_cmd_keeps: assert property (@(posedge clk) disable iff (rst)
    (stat_w[22] && cmd_wr && !rd_hit) |=> stat_w[22]);

  a_r4_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (stat_w[16] && rd_hit && !cmd_wr) |=> stat_w[16]);

  a_r4_cmd_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !evt_set[18]) |=> !stat_w[18]);

  a_r5_read_mode: assert property (@(posedge clk) disable iff (rst)
    (err_ctl && rd_hit && !evt_set[B_UNDERRUN]) |=> !stat_w[B_UNDERRUN]);

  a_r5_cmd_mode: assert property (@(posedge clk) disable iff (rst)
    (!err_ctl && cmd_wr && !evt_set[B_OVERRUN]) |=> !stat_w[B_OVERRUN]);

  a_r5_other_trigger: assert property (@(posedge clk) disable iff (rst)
    (stat_w[B_OVERRUN] && !err_ctl && rd_hit && !cmd_wr) |=> stat_w[B_OVERRUN]);

  a_r6_read_keeps_rx: assert property (@(posedge clk) disable iff (rst)
    (stat_w[B_RXRDY] && rd_hit && !rdr_rd) |=> stat_w[B_RXRDY]);

  a_r6_tdr_clears: assert property (@(posedge clk) disable iff (rst)
    (tdr_wr && !evt_set[B_TXRDY]) |=> !stat_w[B_TXRDY]);

  a_r7_cmd_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !evt_set[B_CMDRDY]) |=> !stat_w[B_CMDRDY]);

  a_r8_nb_clears: assert property (@(posedge clk) disable iff (rst)
    (nb_clr && !evt_set[B_NBUSY]) |=> !stat_w[B_NBUSY]);

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & 32'h0200_CED0) == 32'h0);

endmodule

// File: tb/test_card_status_reg.sv
module test_card_status_reg;

  localparam logic [7:0]  STAT  = 8'h10;
  localparam logic [31:0] RDCLR  = 32'h31E0_2108;
  localparam logic [31:0] CMDCLR = 32'h001F_0001;
  localparam logic [31:0] SEL    = 32'hC000_0000;
  localparam logic [31:0] STICKY = 32'hF1FF_212F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = STAT;
  logic [31:0] rd_data;
  logic        cmd_wr = 1'b0, tdr_wr = 1'b0, rdr_rd = 1'b0, err_ctl = 1'b1;
  logic [31:0] evt_set = '0;
  logic        nb_clr = 1'b0;
  logic        lvl_xfr_done = 1'b0, lvl_fifo_empty = 1'b0, lvl_read_wait = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m;

  always #5 clk = ~clk;

  card_status_reg i_card_status_reg (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_wr(cmd_wr), .tdr_wr(tdr_wr), .rdr_rd(rdr_rd), .err_ctl(err_ctl),
    .evt_set(evt_set), .nb_clr(nb_clr), .lvl_xfr_done(lvl_xfr_done),
    .lvl_fifo_empty(lvl_fifo_empty), .lvl_read_wait(lvl_read_wait));

  function automatic logic [31:0] lvl_word();
    logic [31:0] w = '0;
    w[27] = lvl_xfr_done;
    w[26] = lvl_fifo_empty;
    w[12] = lvl_read_wait;
    return w;
  endfunction

  function automatic string req_of(input logic [31:0] d);
    if (d & SEL)            return "R5";
    if (d & RDCLR)          return "R3";
    if (d & 32'h001F_0000)  return "R4";
    if (d[0])               return "R7";
    if (d & 32'h0000_0006)  return "R6";
    if (d[5])               return "R8";
    if (d & 32'h0C00_1000)  return "R9";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", (tag == "") ? req_of(act ^ exp) : tag, act, exp);
    end
  endtask

  // one clock: model next state from the requirements, then compare read data
  task automatic tick(input string tag);
    logic [31:0] clr, nxt, exp_rd;
    logic        hit;
    hit = rd_en && (rd_addr == STAT);
    clr = '0;
    if (hit)    clr |= RDCLR | (err_ctl ? SEL : 32'h0);
    if (cmd_wr) clr |= CMDCLR | (err_ctl ? 32'h0 : SEL);
    if (tdr_wr) clr |= 32'h4;
    if (rdr_rd) clr |= 32'h2;
    if (nb_clr) clr |= 32'h20;
    nxt    = (m & ~clr) | (evt_set & STICKY);
    exp_rd = hit ? ((m & STICKY) | lvl_word()) : 32'h0;
    @(posedge clk); #1;
    m = nxt;
    if (rd_en) check(tag, rd_data, exp_rd);
    rd_en = 0; rd_addr = STAT; cmd_wr = 0; tdr_wr = 0; rdr_rd = 0; evt_set = '0; nb_clr = 0;
  endtask

  task automatic rd(input string tag);
    rd_en = 1; rd_addr = STAT; tick(tag);
  endtask

  initial begin
    m = 32'h0000_0025;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R2", rd_data, 32'h0);
    rd("R2");                                        // reset image 0x25
    // R3 read-clear group
    evt_set = RDCLR; tick("R3");
    cmd_wr = 1; tick("R3");
    rd("R3"); rd("R3");
    // R4 response errors survive reads, fall on command write
    evt_set = 32'h001F_0000; tick("R4");
    rd("R4"); rd("R4");
    cmd_wr = 1; tick("R4"); rd("R4");
    // R5 both select settings
    err_ctl = 1; evt_set = SEL; tick("R5");
    cmd_wr = 1; tick("R5"); rd("R5"); rd("R5");
    err_ctl = 0; evt_set = SEL; tick("R5");
    rd("R5"); rd("R5"); cmd_wr = 1; tick("R5"); rd("R5");
    err_ctl = 1;
    // R6 data ready flags
    tdr_wr = 1; rdr_rd = 1; tick("R6"); rd("R6");
    evt_set = 32'h6; tick("R6"); rd("R6"); rd("R6");
    tdr_wr = 1; tick("R6"); rd("R6");
    rdr_rd = 1; tick("R6"); rd("R6");
    // R7 command ready
    cmd_wr = 1; tick("R7"); rd("R7");
    evt_set = 32'h1; tick("R7"); rd("R7");
    // R8 not busy
    nb_clr = 1; tick("R8"); rd("R8");
    evt_set = 32'h20; tick("R8"); rd("R8");
    // R9 live levels
    lvl_xfr_done = 1; lvl_read_wait = 1; rd("R9");
    lvl_xfr_done = 0; lvl_fifo_empty = 1; rd("R9");
    lvl_fifo_empty = 0; lvl_read_wait = 0;
    // R10 event coincident with its clear
    evt_set = 32'h2000_0000; rd_en = 1; tick("R10"); rd("R10"); rd("R10");
    evt_set = 32'h0010_0000; cmd_wr = 1; tick("R10"); rd("R10");
    cmd_wr = 1; tick("R10");
    // R11 unused/level positions ignore events
    evt_set = 32'h0E00_DED0; tick("R11"); rd("R11");
    // R1 read at another address returns 0, clears nothing
    evt_set = 32'h0800_0000 | 32'h2000_0000; tick("R1");
    evt_set = 32'h2000_0000; tick("R1");
    rd_en = 1; rd_addr = 8'h14; tick("R1");
    tick("R1");
    check("R1", rd_data, 32'h0);
    rd("R1");
    // random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 800; i++) begin
      rd_en   = ($urandom % 3) == 0;
      rd_addr = (($urandom % 6) == 0) ? 8'h14 : STAT;
      cmd_wr  = ($urandom % 8) == 0;
      tdr_wr  = ($urandom % 6) == 0;
      rdr_rd  = ($urandom % 6) == 0;
      nb_clr  = ($urandom % 8) == 0;
      evt_set = $urandom & $urandom & $urandom;
      if (($urandom % 16) == 0) err_ctl = ~err_ctl;
      lvl_xfr_done = $urandom; lvl_fifo_empty = $urandom; lvl_read_wait = $urandom;
      tick("");
    end
    rd("");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule